// File: doc/BRIEF.md
# Memory-Download Frame Validator

This block sits behind the byte receiver of a serial diagnostic bus and checks one memory-download frame at a time. Bytes arrive with a valid strobe, and the last byte of a frame is marked. The block matches the fixed four-byte frame prefix and reads the sub-mode byte. It then extracts a 16-bit payload length and a 24-bit load address. Each payload byte goes out on a write port as soon as it arrives, to consecutive addresses.

Two nested integrity checks guard the frame. The first is a 16-bit additive block sum over the region from the sub-mode byte to the last payload byte. The second is a CRC-8 in the final byte, which covers everything before it. When the last byte arrives, the block pulses a single pass or fail result together with the reason flags. For a clean frame whose sub-mode asks for execution, it also raises an execute request carrying the load address.

Top module: `dl_frame_check`

## Requirements
- R1: Frame bytes 0..3 must be 0x6D, 0x10, 0xF0, 0x36. Any mismatch sets err_hdr in the result.
- R2: Byte 4 is the sub-mode. It must be 0x80 (load and run) or 0x00 (load only). Any other value sets err_hdr.
- R3: Byte 5 is the length high byte and byte 6 the low byte, giving length L. Bytes 7, 8 and 9 are the load address A, most significant byte first. Bytes 10..9+L are payload.
- R3 (continued): Payload byte k produces exactly one write with wr_addr = (A+k) mod 2^24 and wr_data equal to the byte. The write appears one cycle after the byte is accepted.
- R3 (continued): No other byte produces a write, and a frame with a header fault produces no writes at all.
- R4: A frame must be exactly L+13 bytes. If the end marker arrives earlier or later than that, err_len is set.
- R5: Bytes 10+L (high) and 11+L (low) carry a checksum. It must equal the modulo-2^16 sum of bytes 4..9+L, each byte added as an unsigned value. err_sum reports a mismatch and is evaluated only when the length is correct.
- R6: The final byte must equal a CRC-8 over all preceding bytes of the frame. The CRC uses polynomial 0x1D, initial value 0xFF, MSB first with no reflection, and a final XOR of 0xFF. A mismatch sets err_crc.
- R7: Exactly one of frame_ok and frame_bad pulses for one cycle, one cycle after the last byte. The err flags pulse only in that cycle, and frame_bad is set exactly when at least one err flag is set.
- R8: exec_req pulses together with frame_ok only when the sub-mode is 0x80, with exec_addr equal to A. A load-only frame never raises exec_req.
- R9: Cycles with in_valid low do not advance parsing. All parsing state clears after each end marker, so the next frame is checked on its own.
- R10: After reset, every output is low or zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_byte | input | 8 | Received byte |
| in_valid | input | 1 | in_byte is valid this cycle |
| in_last | input | 1 | Marks the final byte of a frame |
| wr_en | output | 1 | Payload write strobe |
| wr_addr | output | 24 | Write address |
| wr_data | output | 8 | Write data |
| exec_req | output | 1 | Execute request pulse |
| exec_addr | output | 24 | Load address for the execute request |
| frame_ok | output | 1 | Frame passed every check |
| frame_bad | output | 1 | Frame failed at least one check |
| err_hdr | output | 1 | Prefix or sub-mode fault |
| err_len | output | 1 | Frame size does not match the length field |
| err_sum | output | 1 | Block sum mismatch |
| err_crc | output | 1 | CRC mismatch |

## Verification
The bench sweeps lengths 0 through 20 with both sub-modes, with and without idle gaps. An off-by-one in the payload window would show up as a missing or extra write, or as a checksum read from the wrong bytes. Load addresses near the top of the 24-bit space check that writes wrap around rather than carry. Single faults are placed one at a time: each prefix byte, an illegal sub-mode, a wrong checksum under a correct CRC, and a wrong CRC under a correct checksum. A design that mixed up the two checks, or that included the checksum bytes in its own sum, would then report the wrong reason. Frames one byte short and one byte long catch a length test that trusts the end marker. A good frame that follows each bad one catches state left behind from the previous frame.

// File: rtl/dlf_pkg.sv
package dlf_pkg;
  localparam logic [7:0] HDR_B0   = 8'h6D;
  localparam logic [7:0] HDR_B1   = 8'h10;
  localparam logic [7:0] HDR_B2   = 8'hF0;
  localparam logic [7:0] HDR_B3   = 8'h36;
  localparam logic [7:0] SUB_RUN  = 8'h80;
  localparam logic [7:0] SUB_LOAD = 8'h00;

  // One byte through a non-reflected CRC-8, MSB first.
  function automatic logic [7:0] crc8_next(input logic [7:0] cur,
                                           input logic [7:0] din,
                                           input logic [7:0] poly);
    logic [7:0] r;
    r = cur ^ din;
    for (int k = 0; k < 8; k++)
      r = r[7] ? ((r << 1) ^ poly) : (r << 1);
    return r;
  endfunction
endpackage

// File: rtl/dlf_crc8.sv
module dlf_crc8 #(
  parameter logic [7:0] POLY = 8'h1D,
  parameter logic [7:0] INIT = 8'hFF
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       en,
  input  logic [7:0] din,
  output logic [7:0] crc
);
  import dlf_pkg::*;

  always_ff @(posedge clk) begin
    if (rst || clr) crc <= INIT;
    else if (en)    crc <= crc8_next(crc, din, POLY);
  end

  // R6: every frame starts its CRC from the seed value
  a_r6_crc_seed: assert property (@(posedge clk) disable iff (rst)
    clr |=> (crc == INIT));
endmodule

// File: rtl/dlf_sum16.sv
module dlf_sum16 #(
  parameter int SUM_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  input  logic [7:0]       din,
  output logic [SUM_W-1:0] acc
);
  always_ff @(posedge clk) begin
    if (rst || clr) acc <= '0;
    else if (en)    acc <= acc + SUM_W'(din);
  end

  // R5: only bytes inside the summed region move the accumulator
  a_r5_sum_hold: assert property (@(posedge clk) disable iff (rst)
    (!en && !clr) |=> $stable(acc));
  a_r5_sum_clear: assert property (@(posedge clk) disable iff (rst)
    clr |=> (acc == '0));
endmodule

// File: rtl/dl_frame_check.sv
module dl_frame_check #(
  parameter int LEN_W  = 16,
  parameter int ADDR_W = 24,
  parameter int SUM_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        in_byte,
  input  logic              in_valid,
  input  logic              in_last,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              exec_req,
  output logic [ADDR_W-1:0] exec_addr,
  output logic              frame_ok,
  output logic              frame_bad,
  output logic              err_hdr,
  output logic              err_len,
  output logic              err_sum,
  output logic              err_crc
);
  import dlf_pkg::*;

  localparam int POS_W = LEN_W + 2;
  localparam logic [POS_W-1:0] P_B0    = POS_W'(0);
  localparam logic [POS_W-1:0] P_B1    = POS_W'(1);
  localparam logic [POS_W-1:0] P_B2    = POS_W'(2);
  localparam logic [POS_W-1:0] P_B3    = POS_W'(3);
  localparam logic [POS_W-1:0] P_SUB   = POS_W'(4);
  localparam logic [POS_W-1:0] P_LENH  = POS_W'(5);
  localparam logic [POS_W-1:0] P_LENL  = POS_W'(6);
  localparam logic [POS_W-1:0] P_ADR0  = POS_W'(7);
  localparam logic [POS_W-1:0] P_ADR2  = POS_W'(9);
  localparam logic [POS_W-1:0] P_DATA  = POS_W'(10);
  localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};

  logic [POS_W-1:0]  pos;
  logic [LEN_W-1:0]  len_r;
  logic [7:0]        sub_r;
  logic              hdr_bad;
  logic [ADDR_W-1:0] wr_ptr, load_addr;
  logic [SUM_W-1:0]  rx_sum, acc;
  logic [7:0]        crc;

  logic [POS_W-1:0] data_end;
  logic in_data, in_sumreg, hdr_miss, hdr_bad_now;
  logic end_byte, len_ok, sum_ok, crc_ok, all_ok;

  always_comb begin
    data_end  = P_DATA + POS_W'(len_r);
    in_data   = (pos >= P_DATA) && (pos < data_end);
    in_sumreg = ((pos >= P_SUB) && (pos < P_DATA)) || in_data;
    if      (pos == P_B0)  hdr_miss = (in_byte != HDR_B0);
    else if (pos == P_B1)  hdr_miss = (in_byte != HDR_B1);
    else if (pos == P_B2)  hdr_miss = (in_byte != HDR_B2);
    else if (pos == P_B3)  hdr_miss = (in_byte != HDR_B3);
    else if (pos == P_SUB) hdr_miss = !((in_byte == SUB_RUN) || (in_byte == SUB_LOAD));
    else                   hdr_miss = 1'b0;
    hdr_bad_now = hdr_bad || hdr_miss;
    end_byte    = in_valid && in_last;
    len_ok      = (pos == data_end + POS_W'(2));
    sum_ok      = (acc == rx_sum);
    crc_ok      = (in_byte == (crc ^ 8'hFF));
    all_ok      = !hdr_bad_now && len_ok && sum_ok && crc_ok;
  end

  dlf_crc8 #(.POLY(8'h1D), .INIT(8'hFF)) u_crc (
    .clk(clk), .rst(rst), .clr(end_byte), .en(in_valid && !in_last),
    .din(in_byte), .crc(crc)
  );

  dlf_sum16 #(.SUM_W(SUM_W)) u_sum (
    .clk(clk), .rst(rst), .clr(end_byte), .en(in_valid && !in_last && in_sumreg),
    .din(in_byte), .acc(acc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pos <= '0; len_r <= '0; sub_r <= '0; hdr_bad <= 1'b0;
      wr_ptr <= '0; load_addr <= '0; rx_sum <= '0;
      wr_en <= 1'b0; wr_addr <= '0; wr_data <= '0;
      exec_req <= 1'b0; exec_addr <= '0;
      frame_ok <= 1'b0; frame_bad <= 1'b0;
      err_hdr <= 1'b0; err_len <= 1'b0; err_sum <= 1'b0; err_crc <= 1'b0;
    end else begin
      wr_en <= 1'b0; exec_req <= 1'b0;
      frame_ok <= 1'b0; frame_bad <= 1'b0;
      err_hdr <= 1'b0; err_len <= 1'b0; err_sum <= 1'b0; err_crc <= 1'b0;
      if (in_valid) begin
        if (in_data && !hdr_bad_now) begin
          wr_en   <= 1'b1;
          wr_addr <= wr_ptr;
          wr_data <= in_byte;
          wr_ptr  <= wr_ptr + 1'b1;
        end
        if (in_last) begin
          frame_ok  <= all_ok;
          frame_bad <= !all_ok;
          err_hdr   <= hdr_bad_now;
          err_len   <= !len_ok;
          err_sum   <= len_ok && !sum_ok;
          err_crc   <= !crc_ok;
          exec_req  <= all_ok && (sub_r == SUB_RUN);
          exec_addr <= load_addr;
          pos <= '0; len_r <= '0; sub_r <= '0; hdr_bad <= 1'b0; rx_sum <= '0;
        end else begin
          hdr_bad <= hdr_bad_now;
          if (pos != POS_MAX) pos <= pos + 1'b1;
          if (pos == P_SUB)  sub_r <= in_byte;
          if (pos == P_LENH) len_r <= {in_byte, len_r[7:0]};
          if (pos == P_LENL) len_r <= {len_r[LEN_W-1:8], in_byte};
          if ((pos >= P_ADR0) && (pos <= P_ADR2)) begin
            wr_ptr    <= {wr_ptr[ADDR_W-9:0], in_byte};
            load_addr <= {load_addr[ADDR_W-9:0], in_byte};
          end
          if (pos == data_end)               rx_sum <= {in_byte, rx_sum[7:0]};
          if (pos == data_end + POS_W'(1))   rx_sum <= {rx_sum[SUM_W-1:8], in_byte};
        end
      end
    end
  end

  // R7: result pulses are exclusive and follow an end marker
  a_r7_one_result: assert property (@(posedge clk) disable iff (rst)
    !(frame_ok && frame_bad));
  a_r7_after_last: assert property (@(posedge clk) disable iff (rst)
    (frame_ok || frame_bad) |-> $past(in_valid && in_last));
  a_r7_bad_has_reason: assert property (@(posedge clk) disable iff (rst)
    frame_bad |-> (err_hdr || err_len || err_sum || err_crc));
  // R8: execution only for a clean frame
  a_r8_exec_needs_ok: assert property (@(posedge clk) disable iff (rst)
    exec_req |-> frame_ok);
  // R3: writes follow accepted bytes and step by one address
  a_r3_write_follows_byte: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(in_valid));
  a_r3_write_stride: assert property (@(posedge clk) disable iff (rst)
    (wr_en && $past(wr_en)) |-> (wr_addr == $past(wr_addr) + 1'b1));
  // R9: idle cycles never produce output activity
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !$past(in_valid) |-> !(wr_en || frame_ok || frame_bad));
endmodule

// File: tb/sim_dl_frame_check.sv
module sim_dl_frame_check;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst, in_valid, in_last;
  logic [7:0]  in_byte;
  logic        wr_en, exec_req, frame_ok, frame_bad;
  logic        err_hdr, err_len, err_sum, err_crc;
  logic [23:0] wr_addr, exec_addr;
  logic [7:0]  wr_data;

  dl_frame_check u0 (
    .clk(clk), .rst(rst), .in_byte(in_byte), .in_valid(in_valid), .in_last(in_last),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .exec_req(exec_req), .exec_addr(exec_addr),
    .frame_ok(frame_ok), .frame_bad(frame_bad),
    .err_hdr(err_hdr), .err_len(err_len), .err_sum(err_sum), .err_crc(err_crc)
  );

  int n_run = 0, n_fail = 0;
  logic [7:0] fb [0:255];
  int fn;

  task automatic chk(input bit good, input string tag, input longint act, input longint exp);
    n_run++;
    if (!good) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Reference CRC: bitwise shift register, feedback from the top bit.
  function automatic logic [7:0] ref_crc(input int cnt);
    logic [7:0] c = 8'hFF;
    for (int i = 0; i < cnt; i++)
      for (int b = 7; b >= 0; b--) begin
        logic fbk;
        fbk = c[7] ^ fb[i][b];
        c = {c[6:0], 1'b0};
        if (fbk) c = c ^ 8'h1D;
      end
    return c ^ 8'hFF;
  endfunction

  task automatic build(input logic [7:0] sub, input int len, input logic [23:0] addr, input int seed);
    logic [15:0] s = 16'h0;
    fb[0] = 8'h6D; fb[1] = 8'h10; fb[2] = 8'hF0; fb[3] = 8'h36;
    fb[4] = sub;   fb[5] = 8'(len >> 8); fb[6] = 8'(len);
    fb[7] = addr[23:16]; fb[8] = addr[15:8]; fb[9] = addr[7:0];
    for (int i = 0; i < len; i++) fb[10+i] = 8'((seed * 37 + i * 11 + 5) ^ (i << 3));
    for (int i = 4; i < 10 + len; i++) s = s + 16'(fb[i]);
    fb[10+len] = s[15:8]; fb[11+len] = s[7:0];
    fn = len + 13;
    fb[fn-1] = ref_crc(fn - 1);
  endtask

  // Sends fb[0..fn-1]; expectations come from the requirements.
  task automatic send(input bit gaps, input string name);
    int L = 0;
    bit hb = 0, lok, se, ce, ok, ex;
    logic [15:0] s = 16'h0, rxs;
    logic [23:0] a = 24'h0;
    int wmis = 0;
    logic [7:0] hx [0:3];
    hx[0] = 8'h6D; hx[1] = 8'h10; hx[2] = 8'hF0; hx[3] = 8'h36;
    for (int i = 0; i < fn && i < 4; i++) if (fb[i] != hx[i]) hb = 1;
    if (fn > 4 && !(fb[4] == 8'h80 || fb[4] == 8'h00)) hb = 1;
    if (fn > 6) L = {fb[5], fb[6]};
    if (fn > 9) a = {fb[7], fb[8], fb[9]};
    lok = (fn == L + 13);
    se = 0;
    if (lok) begin
      for (int i = 4; i < 10 + L; i++) s = s + 16'(fb[i]);
      rxs = {fb[10+L], fb[11+L]};
      se = (s != rxs);
    end
    ce = (fb[fn-1] != ref_crc(fn - 1));
    ok = !hb && lok && !se && !ce;
    ex = ok && (fb[4] == 8'h80);
    for (int i = 0; i < fn; i++) begin
      bit wexp;
      in_valid = 1'b1; in_byte = fb[i]; in_last = (i == fn - 1);
      @(negedge clk);
      wexp = !hb && (i >= 10) && (i < 10 + L) && (i < fn);
      if (wr_en !== wexp) wmis++;
      else if (wexp && (wr_addr !== 24'(a + 24'(i - 10)) || wr_data !== fb[i])) wmis++;
      if (i != fn - 1 && (frame_ok || frame_bad)) wmis++;
      if (i == fn - 1) begin
        chk(err_hdr == hb, {"R1 R2 err_hdr ", name}, err_hdr, hb);
        chk(err_len == !lok, {"R4 err_len ", name}, err_len, !lok);
        chk(err_sum == se, {"R5 err_sum ", name}, err_sum, se);
        chk(err_crc == ce, {"R6 err_crc ", name}, err_crc, ce);
        chk(frame_ok == ok && frame_bad == !ok, {"R7 result ", name}, {frame_ok, frame_bad}, {ok, !ok});
        chk(exec_req == ex, {"R8 exec_req ", name}, exec_req, ex);
        if (ex) chk(exec_addr == a, {"R8 exec_addr ", name}, exec_addr, a);
      end
      if (gaps && (i % 3 == 0)) begin
        in_valid = 1'b0; in_last = 1'b0;
        @(negedge clk);
        if (wr_en || frame_ok || frame_bad) wmis++; // R9 idle
      end
    end
    in_valid = 1'b0; in_last = 1'b0;
    chk(wmis == 0, {"R3 R9 writes ", name}, wmis, 0);
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_last = 1'b0; in_byte = 8'h0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk({wr_en, exec_req, frame_ok, frame_bad, err_hdr, err_len, err_sum, err_crc} == 8'h0,
        "R10 flags after reset", {wr_en, exec_req, frame_ok, frame_bad}, 0);
    chk(wr_addr == 24'h0 && exec_addr == 24'h0 && wr_data == 8'h0, "R10 data after reset", wr_addr, 0);

    // Sweep lengths and both sub-modes, with and without gaps
    for (int L = 0; L <= 20; L++) begin
      build(8'h80, L, 24'h001000 + 24'(L * 97), L);
      send(L[0], "sweep run");
      build(8'h00, L, 24'hFFFFF8 + 24'(L), L + 50);
      send(!L[0], "sweep load wrap");
    end

    // R1: corrupt each prefix byte, then a clean frame to show state cleared (R9)
    for (int p = 0; p < 4; p++) begin
      build(8'h80, 6, 24'h123456, p);
      fb[p] = fb[p] ^ 8'h01;
      fb[fn-1] = ref_crc(fn - 1);
      send(0, "R1 prefix fault");
      build(8'h80, 4, 24'h000100, p + 9);
      send(0, "R9 recovery");
    end

    // R2: illegal sub-mode
    build(8'h40, 5, 24'h000200, 3);
    fb[fn-1] = ref_crc(fn - 1);
    send(0, "R2 sub-mode 40");

    // R5: checksum wrong, CRC consistent
    build(8'h80, 8, 24'h00ABCD, 7);
    fb[19] = fb[19] ^ 8'h80;
    fb[fn-1] = ref_crc(fn - 1);
    send(1, "R5 block sum");

    // R6: CRC wrong only
    build(8'h00, 8, 24'h00ABCD, 8);
    fb[fn-1] = fb[fn-1] ^ 8'h01;
    send(0, "R6 crc");

    // Payload altered without refresh: both checks fail
    build(8'h80, 3, 24'h000010, 2);
    fb[11] = fb[11] ^ 8'h10;
    send(0, "R5 R6 payload");

    // R4: one byte short, one byte long
    build(8'h80, 5, 24'h000300, 4);
    fn = fn - 1;
    fb[fn-1] = ref_crc(fn - 1);
    send(0, "R4 short");
    build(8'h80, 5, 24'h000300, 4);
    fb[fn] = 8'h00; fn = fn + 1;
    fb[fn-1] = ref_crc(fn - 1);
    send(1, "R4 long");

    build(8'h80, 2, 24'h00FFFF, 1);
    send(0, "final clean");

    repeat (2) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule